// File: doc/BRIEF.md
# Register Rename Map with Pinned-Write Reuse

This block is the destination-renaming stage of an out-of-order core. It maps each architectural destination register to a physical register, and it takes fresh physical registers from a free list that it holds inside. It accepts one rename request per cycle. Each request carries an architectural index and a pinned-write count. The block answers in the same cycle with the new physical tag and the tag that was mapped before.

Each physical register has two counters: the pinned writes still allowed to reuse it, and the writes still to complete. A destination whose current physical register still allows pinned writes keeps that register and uses up one of its allowed writes, so no new register is taken. Architectural register 0 is hard-wired and is never remapped. A release port returns retired physical registers to the tail of the free list. A query port reads both counters of any physical register.

Top module: `rename_pin_map`

## Requirements
- R1: A request for architectural register 0 returns physical tag 0 as both the new and the previous tag. It raises no error, takes nothing from the free list and leaves the map unchanged.
- R2: If the destination's current physical register has a nonzero remaining pinned-write count, the request returns that same register as the new tag, and the count drops by one at the next clock edge.
- R3: In the reuse case of R2, the map entry stays as it is and no free-list entry is consumed.
- R4: `pin_err_o` is high in the cycle of an accepted reuse request whose own pinned-write count is nonzero. The reused register's counters are then not reloaded.
- R5: Any other accepted request takes the head of the free list, which hands out registers in FIFO order. It writes that register into the destination's map entry and returns it as the new tag.
- R6: On such an allocation, the new register's remaining count is loaded with the request's count, and its writes-to-complete counter is loaded with that count plus one.
- R7: `prev_tag_o` is the map entry as it stood before the update of the same cycle. It is valid together with `new_tag_o` while `req_valid_i` is high.
- R8: After reset the map is the identity, every counter is zero, and the free list holds physical registers 32 to 63 in ascending order.
- R9: `req_ready_o` is low only when the request needs an allocation and the free list is empty. Zero-register and reuse requests proceed with an empty list.
- R10: A release pushes its tag at the free-list tail. A release and an allocation in the same cycle both take effect. A tag released into an empty list is not handed to an allocation of the same cycle.
- R11: `qry_left_o` and `qry_cmp_o` show, combinationally, the remaining and writes-to-complete counters of physical register `qry_tag_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Rename request present |
| req_arch_i | input | 5 | Architectural destination index |
| req_pin_i | input | 4 | Requested pinned-write count |
| req_ready_o | output | 1 | Request accepted this cycle when high |
| new_tag_o | output | 6 | Physical tag now holding the destination |
| prev_tag_o | output | 6 | Physical tag mapped before this request |
| pin_err_o | output | 1 | Double-pinning error |
| rel_valid_i | input | 1 | Release a physical register |
| rel_tag_i | input | 6 | Physical register being released |
| qry_tag_i | input | 6 | Physical register whose counters are read |
| qry_left_o | output | 4 | Remaining pinned writes of the queried register |
| qry_cmp_o | output | 5 | Writes to complete of the queried register |

## Verification
The rename function is driven with five kinds of request. Repeated unpinned writes to one register show FIFO allocation and the prev/new chaining. Zero-register requests with a nonzero count separate the hard-wired path from allocation. A pinned allocation followed by exactly as many reuses as its count, and then one more request, shows where reuse ends and allocation begins again. A pinned reuse that itself asks for pinning exposes the error path. Draining the free list, then mixing releases with allocations, separates a real stall from the requests that must still proceed, and shows the order in which released tags return.

// File: rtl/rat_pkg.sv
package rat_pkg;
  typedef enum logic [1:0] {
    ACT_ZERO  = 2'd0,
    ACT_REUSE = 2'd1,
    ACT_ALLOC = 2'd2
  } rat_act_e;
endpackage

// File: rtl/rat_map_table.sv
module rat_map_table #(
  parameter int NUM_ARCH = 32,
  parameter int NUM_PHYS = 64,
  localparam int AW = $clog2(NUM_ARCH),
  localparam int PW = $clog2(NUM_PHYS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] rd_idx_i,
  output logic [PW-1:0] rd_tag_o,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_idx_i,
  input  logic [PW-1:0] wr_tag_i
);
  logic [PW-1:0] map_q [NUM_ARCH];

  assign rd_tag_o = map_q[rd_idx_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_ARCH; i++) map_q[i] <= PW'(i);
    end else if (wr_en_i) begin
      map_q[wr_idx_i] <= wr_tag_i;
    end
  end
endmodule

// File: rtl/rat_free_fifo.sv
module rat_free_fifo #(
  parameter int NUM_ARCH = 32,
  parameter int NUM_PHYS = 64,
  localparam int PW    = $clog2(NUM_PHYS),
  localparam int CW    = $clog2(NUM_PHYS + 1),
  localparam int FREE0 = NUM_PHYS - NUM_ARCH
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pop_i,
  input  logic          push_i,
  input  logic [PW-1:0] push_tag_i,
  output logic [PW-1:0] head_o,
  output logic          empty_o,
  output logic [CW-1:0] count_o
);
  logic [PW-1:0] mem_q [NUM_PHYS];
  logic [PW-1:0] rd_q, wr_q;
  logic [CW-1:0] cnt_q;
  logic          push_ok, pop_ok;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (int'(p) == NUM_PHYS - 1) ? '0 : p + 1'b1;
  endfunction

  assign empty_o = (cnt_q == '0);
  assign head_o  = mem_q[rd_q];
  assign count_o = cnt_q;
  assign pop_ok  = pop_i && !empty_o;
  assign push_ok = push_i && (int'(cnt_q) < NUM_PHYS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_PHYS; i++)
        mem_q[i] <= (i < FREE0) ? PW'(i + NUM_ARCH) : '0;
      rd_q  <= '0;
      wr_q  <= PW'(FREE0 % NUM_PHYS);
      cnt_q <= CW'(FREE0);
    end else begin
      if (push_ok) begin
        mem_q[wr_q] <= push_tag_i;
        wr_q        <= nxt(wr_q);
      end
      if (pop_ok) rd_q <= nxt(rd_q);
      cnt_q <= cnt_q + CW'(push_ok) - CW'(pop_ok);
    end
  end
endmodule

// File: rtl/rat_pin_ctrs.sv
module rat_pin_ctrs #(
  parameter int NUM_PHYS = 64,
  parameter int PIN_W    = 4,
  localparam int PW = $clog2(NUM_PHYS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ld_en_i,
  input  logic [PW-1:0]    ld_tag_i,
  input  logic [PIN_W-1:0] ld_val_i,
  input  logic             dec_en_i,
  input  logic [PW-1:0]    dec_tag_i,
  input  logic [PW-1:0]    rd_tag_i,
  output logic [PIN_W-1:0] rd_left_o,
  input  logic [PW-1:0]    qry_tag_i,
  output logic [PIN_W-1:0] qry_left_o,
  output logic [PIN_W:0]   qry_cmp_o
);
  logic [PIN_W-1:0] left_q [NUM_PHYS];
  logic [PIN_W:0]   cmp_q  [NUM_PHYS];

  assign rd_left_o  = left_q[rd_tag_i];
  assign qry_left_o = left_q[qry_tag_i];
  assign qry_cmp_o  = cmp_q[qry_tag_i];

  for (genvar g = 0; g < NUM_PHYS; g++) begin : g_ctr
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        left_q[g] <= '0;
        cmp_q[g]  <= '0;
      end else if (ld_en_i && int'(ld_tag_i) == g) begin
        left_q[g] <= ld_val_i;
        cmp_q[g]  <= {1'b0, ld_val_i} + 1'b1;
      end else if (dec_en_i && int'(dec_tag_i) == g && left_q[g] != '0) begin
        left_q[g] <= left_q[g] - 1'b1;
      end
    end
  end
endmodule

// File: rtl/rename_pin_map.sv
module rename_pin_map
  import rat_pkg::*;
#(
  parameter int NUM_ARCH  = 32,
  parameter int NUM_PHYS  = 64,
  parameter int PIN_W     = 4,
  parameter int ZERO_ARCH = 0,
  localparam int AW = $clog2(NUM_ARCH),
  localparam int PW = $clog2(NUM_PHYS),
  localparam int CW = $clog2(NUM_PHYS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [AW-1:0]    req_arch_i,
  input  logic [PIN_W-1:0] req_pin_i,
  output logic             req_ready_o,
  output logic [PW-1:0]    new_tag_o,
  output logic [PW-1:0]    prev_tag_o,
  output logic             pin_err_o,
  input  logic             rel_valid_i,
  input  logic [PW-1:0]    rel_tag_i,
  input  logic [PW-1:0]    qry_tag_i,
  output logic [PIN_W-1:0] qry_left_o,
  output logic [PIN_W:0]   qry_cmp_o
);
  rat_act_e         act;
  logic [PW-1:0]    prev_tag, fl_head;
  logic [PIN_W-1:0] prev_left;
  logic             fl_empty, fire, do_alloc, do_reuse;
  logic [CW-1:0]    fl_count;

  always_comb begin
    if (int'(req_arch_i) == ZERO_ARCH) act = ACT_ZERO;
    else if (prev_left != '0)          act = ACT_REUSE;
    else                               act = ACT_ALLOC;
  end

  assign req_ready_o = !(act == ACT_ALLOC && fl_empty);
  assign fire        = req_valid_i && req_ready_o;
  assign do_alloc    = fire && act == ACT_ALLOC;
  assign do_reuse    = fire && act == ACT_REUSE;
  assign prev_tag_o  = prev_tag;
  assign new_tag_o   = (act == ACT_ALLOC) ? fl_head : prev_tag;
  assign pin_err_o   = do_reuse && req_pin_i != '0;

  rat_map_table #(.NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS)) i_map (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_idx_i (req_arch_i),
    .rd_tag_o (prev_tag),
    .wr_en_i  (do_alloc),
    .wr_idx_i (req_arch_i),
    .wr_tag_i (fl_head)
  );

  rat_free_fifo #(.NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS)) i_free (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pop_i      (do_alloc),
    .push_i     (rel_valid_i),
    .push_tag_i (rel_tag_i),
    .head_o     (fl_head),
    .empty_o    (fl_empty),
    .count_o    (fl_count)
  );

  rat_pin_ctrs #(.NUM_PHYS(NUM_PHYS), .PIN_W(PIN_W)) i_pin (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ld_en_i    (do_alloc),
    .ld_tag_i   (fl_head),
    .ld_val_i   (req_pin_i),
    .dec_en_i   (do_reuse),
    .dec_tag_i  (prev_tag),
    .rd_tag_i   (prev_tag),
    .rd_left_o  (prev_left),
    .qry_tag_i  (qry_tag_i),
    .qry_left_o (qry_left_o),
    .qry_cmp_o  (qry_cmp_o)
  );
endmodule

// File: rtl/rename_pin_map_chk.sv
module rename_pin_map_chk #(
  parameter int NUM_PHYS  = 64,
  parameter int ZERO_ARCH = 0,
  parameter int AW = 5,
  parameter int PW = 6,
  parameter int PIN_W = 4,
  parameter int CW = 7
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic [AW-1:0]    req_arch_i,
  input logic [PIN_W-1:0] req_pin_i,
  input logic             req_ready_o,
  input logic [PW-1:0]    new_tag_o,
  input logic [PW-1:0]    prev_tag_o,
  input logic             pin_err_o,
  input logic             rel_valid_i,
  input logic             fl_empty,
  input logic [CW-1:0]    fl_count
);
  logic fire;
  assign fire = req_valid_i && req_ready_o;

  AST_ZERO_SAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire && int'(req_arch_i) == ZERO_ARCH |-> new_tag_o == prev_tag_o && !pin_err_o); // R1
  AST_REUSE_NO_POP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire && int'(req_arch_i) != ZERO_ARCH && new_tag_o == prev_tag_o
      |=> int'(fl_count) >= int'($past(fl_count))); // R3
  AST_ERR_ON_REUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pin_err_o |-> fire && new_tag_o == prev_tag_o && req_pin_i != '0); // R4
  AST_ALLOC_POPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire && new_tag_o != prev_tag_o
      |=> int'(fl_count) == int'($past(fl_count)) - 1 + int'($past(rel_valid_i))); // R5
  AST_STALL_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && !req_ready_o |-> fl_empty); // R9
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(fl_count) <= NUM_PHYS); // R10
endmodule

bind rename_pin_map rename_pin_map_chk #(
  .NUM_PHYS(NUM_PHYS), .ZERO_ARCH(ZERO_ARCH), .AW(AW), .PW(PW), .PIN_W(PIN_W), .CW(CW)
) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_arch_i  (req_arch_i),
  .req_pin_i   (req_pin_i),
  .req_ready_o (req_ready_o),
  .new_tag_o   (new_tag_o),
  .prev_tag_o  (prev_tag_o),
  .pin_err_o   (pin_err_o),
  .rel_valid_i (rel_valid_i),
  .fl_empty    (fl_empty),
  .fl_count    (fl_count)
);

// File: tb/test_rename_pin_map.sv
`timescale 1ns/1ps
module test_rename_pin_map;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       req_valid_i = 1'b0;
  logic [4:0] req_arch_i = '0;
  logic [3:0] req_pin_i = '0;
  logic       req_ready_o;
  logic [5:0] new_tag_o, prev_tag_o;
  logic       pin_err_o;
  logic       rel_valid_i = 1'b0;
  logic [5:0] rel_tag_i = '0;
  logic [5:0] qry_tag_i = '0;
  logic [3:0] qry_left_o;
  logic [4:0] qry_cmp_o;

  int checks = 0, errors = 0;
  int m_map[32];
  int m_left[64];
  int m_cmp[64];
  int fl[$];

  always #10 clk_i = ~clk_i;

  rename_pin_map i_rename_pin_map (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .req_valid_i(req_valid_i), .req_arch_i(req_arch_i), .req_pin_i(req_pin_i),
    .req_ready_o(req_ready_o), .new_tag_o(new_tag_o), .prev_tag_o(prev_tag_o),
    .pin_err_o(pin_err_o), .rel_valid_i(rel_valid_i), .rel_tag_i(rel_tag_i),
    .qry_tag_i(qry_tag_i), .qry_left_o(qry_left_o), .qry_cmp_o(qry_cmp_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // one cycle of request and/or release, checked against the model
  task automatic cyc(input bit v, input int arch, input int pin,
                     input bit rv, input int rt, input string req);
    int prev, exp_new;
    bit zero, reuse, alloc, exp_rdy, exp_err;
    @(negedge clk_i);
    req_valid_i = v; req_arch_i = 5'(arch); req_pin_i = 4'(pin);
    rel_valid_i = rv; rel_tag_i = 6'(rt);
    #1;
    prev    = m_map[arch];
    zero    = (arch == 0);
    reuse   = !zero && m_left[prev] > 0;
    alloc   = !zero && !reuse;
    exp_rdy = !(alloc && fl.size() == 0);
    exp_new = alloc ? ((fl.size() > 0) ? fl[0] : -1) : prev;
    exp_err = v && reuse && pin != 0;
    if (v) begin
      chk(req_ready_o == exp_rdy, req, "ready", int'(req_ready_o), int'(exp_rdy));
      if (exp_rdy) begin
        chk(int'(new_tag_o) == exp_new, req, "new_tag", int'(new_tag_o), exp_new);
        chk(int'(prev_tag_o) == prev, req, "prev_tag", int'(prev_tag_o), prev);
        chk(pin_err_o == exp_err, req, "pin_err", int'(pin_err_o), int'(exp_err));
      end
    end
    @(posedge clk_i);
    if (v && exp_rdy) begin
      if (alloc) begin
        void'(fl.pop_front());
        m_map[arch] = exp_new; m_left[exp_new] = pin; m_cmp[exp_new] = pin + 1;
      end else if (reuse) begin
        m_left[prev]--;
      end
    end
    if (rv && fl.size() < 64) fl.push_back(rt);
    #1;
    req_valid_i = 1'b0; rel_valid_i = 1'b0;
  endtask

  task automatic qchk(input int tag, input string req);
    @(negedge clk_i);
    qry_tag_i = 6'(tag);
    #1;
    chk(int'(qry_left_o) == m_left[tag], req, "left", int'(qry_left_o), m_left[tag]);
    chk(int'(qry_cmp_o) == m_cmp[tag], req, "to_complete", int'(qry_cmp_o), m_cmp[tag]);
  endtask

  task automatic t_reset();
    // R8: identity map, zero counters, 32 ascending in free list
    for (int i = 0; i < 32; i++) m_map[i] = i;
    for (int i = 0; i < 64; i++) begin m_left[i] = 0; m_cmp[i] = 0; end
    fl.delete();
    for (int i = 32; i < 64; i++) fl.push_back(i);
    #1;
    chk(req_ready_o == 1'b1, "R8", "ready_in_reset", int'(req_ready_o), 1);
    qchk(5, "R8");
    qchk(63, "R8");
  endtask

  task automatic t_alloc();
    cyc(1, 5, 0, 0, 0, "R5");   // new 32, prev 5
    cyc(1, 5, 0, 0, 0, "R7");   // new 33, prev 32
    cyc(1, 6, 3, 0, 0, "R6");
    qchk(34, "R6");
    qchk(33, "R11");
  endtask

  task automatic t_zero();
    cyc(1, 0, 3, 0, 0, "R1");
    cyc(1, 0, 0, 0, 0, "R1");
    cyc(1, 8, 0, 0, 0, "R1");   // head not consumed by zero requests
    qchk(0, "R1");
  endtask

  task automatic t_pin();
    cyc(1, 7, 2, 0, 0, "R6");
    qchk(36, "R6");
    cyc(1, 7, 0, 0, 0, "R2");
    qchk(36, "R2");
    cyc(1, 7, 0, 0, 0, "R3");
    qchk(36, "R2");
    cyc(1, 7, 0, 0, 0, "R5");   // count spent: fresh allocation
    cyc(1, 6, 0, 0, 0, "R3");   // arch 6 pinned 3 earlier: reuse 34
    cyc(1, 9, 0, 0, 0, "R3");   // next fresh tag follows on, no gap
  endtask

  task automatic t_err();
    cyc(1, 9, 1, 0, 0, "R6");
    cyc(1, 9, 2, 0, 0, "R4");
    qchk(int'(m_map[9]), "R4");
    cyc(1, 9, 0, 0, 0, "R4");
  endtask

  task automatic t_empty();
    int guard = 0;
    cyc(1, 10, 1, 0, 0, "R6");
    while (fl.size() > 0 && guard < 70) begin
      cyc(1, 11, 0, 0, 0, "R5");
      guard++;
    end
    cyc(1, 12, 0, 0, 0, "R9");   // stalled
    cyc(1, 0, 0, 0, 0, "R9");    // zero still proceeds
    cyc(1, 10, 0, 0, 0, "R9");   // reuse still proceeds
    cyc(1, 12, 0, 1, 40, "R10"); // stalled, 40 pushed
    cyc(1, 12, 0, 0, 0, "R10");  // gets 40
    cyc(0, 0, 0, 1, 41, "R10");
    cyc(0, 0, 0, 1, 42, "R10");
    cyc(1, 13, 0, 1, 43, "R10"); // gets 41, 43 pushed
    cyc(1, 14, 0, 0, 0, "R10");  // 42
    cyc(1, 15, 0, 0, 0, "R10");  // 43
    cyc(1, 16, 0, 0, 0, "R9");   // empty again
  endtask

  initial begin
    #(20ns * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    t_reset();
    @(negedge clk_i);
    rst_ni = 1'b1;
    t_alloc();
    t_zero();
    t_pin();
    t_err();
    t_empty();
    repeat (2) @(negedge clk_i);
    finish_run();
  end
endmodule